// File: doc/BRIEF.md
# Display Sync Timing Generator

This block derives horizontal and vertical synchronisation for a low-resolution raster display from a single system clock. A pixel-position counter sets the line period and places an active-low horizontal sync pulse near the end of each line. A line counter advances once per line. A small phase machine walks each frame through four vertical phases in a fixed order: back porch, visible region, front porch, vertical sync. The line counter returns to zero when the vertical sync phase ends.

A scanout engine in the same clock domain uses the outputs to time its pixel fetches. The line-start strobe marks the first cycle of each line, and the visible flag marks the cycles in which pixels are shown. The current line count is provided as well. The vertical sync level changes only at a line boundary: it goes low one line after the sync phase is entered and returns high one line after the phase is left. No data moves through the block, so every port is a plain control or status pin and there is no valid/ready handshake.

With the default parameters, a 30 MHz clock gives lines of 937 cycles and frames of 531 lines.

Top module: `sync_timing_gen`

## Requirements
- R1: The horizontal position counter runs from 0 to H_LIMIT (default 936) inclusive, so a line lasts H_LIMIT+1 cycles. `line_start` is high for exactly one cycle: the cycle in which the position has just wrapped back to 0. It stays low in the first line after reset.
- R2: `hsync_n` is low exactly while the horizontal position is at least HS_START (default 800) and below HS_START+HS_LEN (default 800+112=912). It is high at all other positions.
- R3: `line_count` is 0 after reset. It increases by one in the same cycle that `line_start` rises, and it holds its value in every other cycle.
- R4: Each vertical phase is chosen from the line count after it has been incremented. Lines 0 to V_VIS_START-1 (default 14) are back porch. Lines V_VIS_START to V_FP_START-1 (15 to 526) are visible. Lines V_FP_START to V_VS_START-1 (527 to 528) are front porch. Lines V_VS_START to V_VS_END-1 (529 to 530) are vertical sync. When the count would reach V_VS_END (531), it becomes 0 and the back porch starts again, so `line_count` never shows V_VS_END.
- R5: `vsync_n` is sampled once per line, at the line start, and reflects whether the previous line was in the sync phase. It is therefore low in lines V_VS_START+1 to V_VS_END-1 and in line 0 of every frame after the first (by default lines 530 and 0). It changes only in a cycle where `line_start` is high.
- R6: `visible` is high only when the current line is in the visible phase and the horizontal position is below HS_START.
- R7: A synchronous active-high `rst` sets both counters to 0 and the phase to back porch. While reset is held and in the cycle after it, `hsync_n` and `vsync_n` are high and `line_start` and `visible` are low. This applies whether reset comes at start-up or in the middle of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low, updated at line starts |
| line_start | output | 1 | One-cycle strobe on the first cycle of each line |
| visible | output | 1 | High while pixels are shown |
| line_count | output | $clog2(V_VS_END+1) | Current line number within the frame |

## Verification
Two functions share a cycle at each line wrap: the line counter increments, the vertical phase may change, and the vertical sync level may switch, all on the same edge that raises `line_start`. Separately, when the horizontal position reaches HS_START, hsync falls and the visible flag drops in the same cycle. The bench runs a small-parameter instance through several whole frames, including a reset in the middle of a frame, so that every phase boundary and the frame wrap occur many times. A default-parameter instance runs for its first lines alongside it. Each cycle is judged against a model that computes position, line and phase arithmetically from the number of clock edges since reset, so any skew by one cycle or one line between these coinciding events appears as a mismatch.

// File: rtl/sync_timing_pkg.sv
package sync_timing_pkg;
  typedef enum logic [1:0] {
    PH_BACK   = 2'd0,
    PH_ACTIVE = 2'd1,
    PH_FRONT  = 2'd2,
    PH_SYNC   = 2'd3
  } vphase_t;
endpackage

// File: rtl/line_timer.sv
module line_timer #(
  parameter int H_LIMIT  = 936,
  parameter int HS_START = 800,
  parameter int HS_LEN   = 112,
  localparam int HW      = $clog2(H_LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [HW-1:0] h_pos,
  output logic          wrap,
  output logic          line_start,
  output logic          hsync_n
);
  localparam logic [HW-1:0] H_MAX  = HW'(H_LIMIT);
  localparam int            HS_END = HS_START + HS_LEN;

  assign wrap = (h_pos == H_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      h_pos      <= '0;
      line_start <= 1'b0;
    end else begin
      h_pos      <= wrap ? '0 : h_pos + 1'b1;
      line_start <= wrap;
    end
  end

  always_comb begin
    hsync_n = 1'b1;
    if (int'(h_pos) >= HS_START && int'(h_pos) < HS_END) hsync_n = 1'b0;
  end
endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer
  import sync_timing_pkg::*;
#(
  parameter int V_VIS_START = 15,
  parameter int V_FP_START  = 527,
  parameter int V_VS_START  = 529,
  parameter int V_VS_END    = 531,
  localparam int LW         = $clog2(V_VS_END + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wrap,
  output logic [LW-1:0] line_count,
  output vphase_t       phase,
  output logic          vsync_n
);
  localparam logic [LW-1:0] L_VIS = LW'(V_VIS_START);
  localparam logic [LW-1:0] L_FP  = LW'(V_FP_START);
  localparam logic [LW-1:0] L_VS  = LW'(V_VS_START);
  localparam logic [LW-1:0] L_END = LW'(V_VS_END);

  logic [LW-1:0] inc_count;
  logic [LW-1:0] count_d;
  vphase_t       phase_d;

  assign inc_count = line_count + 1'b1;

  always_comb begin
    count_d = inc_count;
    phase_d = phase;
    unique case (phase)
      PH_BACK:   if (inc_count >= L_VIS) phase_d = PH_ACTIVE;
      PH_ACTIVE: if (inc_count >= L_FP)  phase_d = PH_FRONT;
      PH_FRONT:  if (inc_count >= L_VS)  phase_d = PH_SYNC;
      PH_SYNC: begin
        if (inc_count >= L_END) begin
          count_d = '0;
          phase_d = PH_BACK;
        end
      end
      default: phase_d = PH_BACK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_count <= '0;
      phase      <= PH_BACK;
      vsync_n    <= 1'b1;
    end else if (wrap) begin
      line_count <= count_d;
      phase      <= phase_d;
      vsync_n    <= (phase != PH_SYNC);
    end
  end
endmodule

// File: rtl/sync_timing_gen.sv
module sync_timing_gen
  import sync_timing_pkg::*;
#(
  parameter int H_LIMIT     = 936,
  parameter int HS_START    = 800,
  parameter int HS_LEN      = 112,
  parameter int V_VIS_START = 15,
  parameter int V_FP_START  = 527,
  parameter int V_VS_START  = 529,
  parameter int V_VS_END    = 531,
  localparam int HW         = $clog2(H_LIMIT + 1),
  localparam int LW         = $clog2(V_VS_END + 1)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          line_start,
  output logic          visible,
  output logic [LW-1:0] line_count
);
  logic [HW-1:0] h_pos;
  logic          wrap;
  vphase_t       phase;

  line_timer #(
    .H_LIMIT (H_LIMIT),
    .HS_START(HS_START),
    .HS_LEN  (HS_LEN)
  ) u_line (
    .clk       (clk),
    .rst       (rst),
    .h_pos     (h_pos),
    .wrap      (wrap),
    .line_start(line_start),
    .hsync_n   (hsync_n)
  );

  frame_sequencer #(
    .V_VIS_START(V_VIS_START),
    .V_FP_START (V_FP_START),
    .V_VS_START (V_VS_START),
    .V_VS_END   (V_VS_END)
  ) u_frame (
    .clk       (clk),
    .rst       (rst),
    .wrap      (wrap),
    .line_count(line_count),
    .phase     (phase),
    .vsync_n   (vsync_n)
  );

  assign visible = (phase == PH_ACTIVE) && (int'(h_pos) < HS_START);
endmodule

// File: rtl/sync_timing_chk.sv
module sync_timing_chk #(
  parameter int V_VS_END = 531,
  localparam int LW      = $clog2(V_VS_END + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          hsync_n,
  input logic          vsync_n,
  input logic          line_start,
  input logic          visible,
  input logic [LW-1:0] line_count
);
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    line_start |=> !line_start); // R1

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !line_start |-> $stable(line_count)); // R3

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    line_start |-> (line_count == $past(line_count) + 1'b1) || (line_count == '0)); // R3

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(line_count) < V_VS_END); // R4

  AST_VSYNC_AT_LINE: assert property (@(posedge clk) disable iff (rst)
    !line_start |-> $stable(vsync_n)); // R5

  AST_HSYNC_BLANKS: assert property (@(posedge clk) disable iff (rst)
    !hsync_n |-> !visible); // R6

  AST_VSYNC_BLANKS: assert property (@(posedge clk) disable iff (rst)
    !vsync_n |-> !visible); // R5
endmodule

bind sync_timing_gen sync_timing_chk #(.V_VS_END(V_VS_END)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .hsync_n   (hsync_n),
  .vsync_n   (vsync_n),
  .line_start(line_start),
  .visible   (visible),
  .line_count(line_count)
);

// File: tb/sync_timing_gen_tb_top.sv
module sync_ref_model #(
  parameter int H_LIMIT     = 936,
  parameter int HS_START    = 800,
  parameter int HS_LEN      = 112,
  parameter int V_VIS_START = 15,
  parameter int V_FP_START  = 527,
  parameter int V_VS_START  = 529,
  parameter int V_VS_END    = 531
) (
  input  logic clk,
  input  logic rst,
  output logic e_hsync_n,
  output logic e_vsync_n,
  output logic e_line_start,
  output logic e_visible,
  output int   e_line
);
  int edges = 0;
  int pos, line_idx;

  always @(posedge clk) begin
    if (rst) edges <= 0;
    else     edges <= edges + 1;
  end

  always_comb begin
    pos          = edges % (H_LIMIT + 1);
    line_idx     = edges / (H_LIMIT + 1);
    e_line       = line_idx % V_VS_END;
    e_line_start = (pos == 0) && (edges > 0);
    e_hsync_n    = !(pos >= HS_START && pos < HS_START + HS_LEN);
    e_vsync_n    = !((e_line > V_VS_START && e_line < V_VS_END) ||
                     (e_line == 0 && line_idx > 0));
    e_visible    = (e_line >= V_VIS_START) && (e_line < V_FP_START) && (pos < HS_START);
  end
endmodule

module sync_timing_gen_tb_top;
  localparam int SH_LIMIT = 20;
  localparam int SHS_ST   = 12;
  localparam int SHS_LEN  = 4;
  localparam int SV_VIS   = 3;
  localparam int SV_FP    = 8;
  localparam int SV_VS    = 10;
  localparam int SV_END   = 12;
  localparam int SLW      = $clog2(SV_END + 1);
  localparam int DLW      = $clog2(531 + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit comparing = 1'b0;
  bit finished  = 1'b0;

  logic           s_hs, s_vs, s_ls, s_vis;
  logic [SLW-1:0] s_line;
  logic           d_hs, d_vs, d_ls, d_vis;
  logic [DLW-1:0] d_line;
  logic           es_hs, es_vs, es_ls, es_vis;
  int             es_line;
  logic           ed_hs, ed_vs, ed_ls, ed_vis;
  int             ed_line;

  sync_timing_gen #(
    .H_LIMIT(SH_LIMIT), .HS_START(SHS_ST), .HS_LEN(SHS_LEN),
    .V_VIS_START(SV_VIS), .V_FP_START(SV_FP), .V_VS_START(SV_VS), .V_VS_END(SV_END)
  ) dut_i (
    .clk(clk), .rst(rst), .hsync_n(s_hs), .vsync_n(s_vs),
    .line_start(s_ls), .visible(s_vis), .line_count(s_line)
  );

  sync_timing_gen dut_def_i (
    .clk(clk), .rst(rst), .hsync_n(d_hs), .vsync_n(d_vs),
    .line_start(d_ls), .visible(d_vis), .line_count(d_line)
  );

  sync_ref_model #(
    .H_LIMIT(SH_LIMIT), .HS_START(SHS_ST), .HS_LEN(SHS_LEN),
    .V_VIS_START(SV_VIS), .V_FP_START(SV_FP), .V_VS_START(SV_VS), .V_VS_END(SV_END)
  ) ref_s (
    .clk(clk), .rst(rst), .e_hsync_n(es_hs), .e_vsync_n(es_vs),
    .e_line_start(es_ls), .e_visible(es_vis), .e_line(es_line)
  );

  sync_ref_model ref_d (
    .clk(clk), .rst(rst), .e_hsync_n(ed_hs), .e_vsync_n(ed_vs),
    .e_line_start(ed_ls), .e_visible(ed_vis), .e_line(ed_line)
  );

  task automatic check_val(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (comparing && !finished) begin
      check_val("R1 line_start small", int'(s_ls), int'(es_ls));
      check_val("R2 hsync_n small", int'(s_hs), int'(es_hs));
      check_val("R3 R4 line_count small", int'(s_line), es_line);
      check_val("R5 vsync_n small", int'(s_vs), int'(es_vs));
      check_val("R6 visible small", int'(s_vis), int'(es_vis));
      check_val("R1 line_start default", int'(d_ls), int'(ed_ls));
      check_val("R2 hsync_n default", int'(d_hs), int'(ed_hs));
      check_val("R3 line_count default", int'(d_line), ed_line);
      check_val("R5 vsync_n default", int'(d_vs), int'(ed_vs));
      check_val("R6 visible default", int'(d_vis), int'(ed_vis));
    end
  end

  task automatic check_reset_state(input string tag);
    check_val({tag, " R7 hsync_n"}, int'(s_hs), 1);
    check_val({tag, " R7 vsync_n"}, int'(s_vs), 1);
    check_val({tag, " R7 line_start"}, int'(s_ls), 0);
    check_val({tag, " R7 visible"}, int'(s_vis), 0);
    check_val({tag, " R7 line_count"}, int'(s_line), 0);
    check_val({tag, " R7 default line_count"}, int'(d_line), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_state("startup");
    comparing = 1'b1;
    rst = 1'b0;
    repeat (1130) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_reset_state("midrun");
    rst = 1'b0;
    repeat (700) @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule